// File: doc/BRIEF.md
# Pairwise Vote Class Selector

This block turns a set of pairwise binary decisions into one multiclass result. It receives one accumulated decision sum for every unordered pair of classes, together with a matching table of per-pair offsets. For each pair it tests whether the sum exceeds the offset. The outcome awards one vote to one of the two classes. The block counts the votes of every class and reports the class with the largest count.

All pair comparisons are evaluated side by side in a single register stage. A second stage counts the votes and selects the winner. A new set of sums may be offered on every clock cycle, and each accepted set produces exactly one qualified result a fixed number of cycles later. The producer of the sums and the holder of the offset table sit outside this block. The offset bus must hold its values in any cycle where the input is qualified.

Top module: `ovo_vote_top`

## Requirements
- R1: Pair (i, j) with i < j uses field index d, where d counts the pairs in lexicographic order: (0,1)=0, (0,2)=1, …, (0,7)=6, (1,2)=7, …, (6,7)=27. Field d occupies bits [26*d+25 : 26*d] of both the sum bus and the offset bus.
- R2: For pair d = (i, j), class i gains the vote when sum_d − offset_d > 0. In every other case, including equality, class j gains the vote.
- R3: Sums and offsets are 26-bit two's complement values (15 integer bits, 11 fractional bits). The comparison is exact across the full range, with no wraparound, even when the operands have opposite extreme signs.
- R4: The result is the class with the highest vote count. It is encoded in 3 bits as the class label minus one, giving codes 0 to 7.
- R5: When several classes share the highest count, the lowest code among them is reported.
- R6: `res_valid` is high for exactly one cycle, two clock cycles after each cycle in which `sum_valid` is sampled high. Inputs on consecutive cycles each yield their own result on consecutive cycles.
- R7: `res_class` keeps its last value in every cycle where `res_valid` is low.
- R8: While `rst_n` is low, `res_valid` is 0 and `res_class` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sum_valid | input | 1 | Qualifies `sum_bus` and `bias_bus` for this cycle |
| sum_bus | input | 728 | 28 packed signed decision sums, pair order per R1 |
| bias_bus | input | 728 | 28 packed signed per-pair offsets, same layout |
| res_valid | output | 1 | Result qualifier |
| res_class | output | 3 | Winning class code (label minus one) |

## Verification
Two functions can fall in the same cycle. The first is loading a new result. The second is holding the previous one while a fresh set of sums enters the compare stage. Back-to-back and gapped input bursts provoke this overlap. In every cycle the bench compares the class output against either the new expected winner or the held value, as the input history two cycles earlier dictates.

Ties between the leading classes can also coincide with boundary comparisons, such as equal operands or operands of opposite extreme signs. Directed cyclic vote patterns and random near-equal operands provoke these cases. A bench model that counts votes from the signed pair differences judges them.

// File: rtl/ovo_vote_pkg.sv
package ovo_vote_pkg;

  localparam int unsigned DEF_NUM_CLASSES = 8;
  localparam int unsigned DEF_SUM_W       = 26;

  // Lexicographic index of pair (lo, hi), lo < hi, among ncls classes.
  function automatic int unsigned pair_index(input int unsigned lo,
                                             input int unsigned hi,
                                             input int unsigned ncls);
    return (lo * (2 * ncls - lo - 1)) / 2 + (hi - lo - 1);
  endfunction

endpackage

// File: rtl/ovo_pair_cmp.sv
module ovo_pair_cmp #(
  parameter int unsigned SUM_W = 26
) (
  input  logic [SUM_W-1:0] sum_i,
  input  logic [SUM_W-1:0] bias_i,
  output logic             lo_wins_o
);

  // One guard bit keeps the signed difference exact over the full range.
  logic [SUM_W:0] diff;

  always_comb begin
    diff      = {sum_i[SUM_W-1], sum_i} - {bias_i[SUM_W-1], bias_i};
    lo_wins_o = ~diff[SUM_W] & (diff != '0);
  end

endmodule

// File: rtl/ovo_vote_tally.sv
module ovo_vote_tally
  import ovo_vote_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = 8,
  parameter int unsigned VOTE_W      = 3,
  localparam int unsigned NUM_PAIRS  = NUM_CLASSES * (NUM_CLASSES - 1) / 2
) (
  input  logic [NUM_PAIRS-1:0]          lo_wins_i,
  output logic [NUM_CLASSES*VOTE_W-1:0] votes_o
);

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    logic [VOTE_W-1:0] cnt;

    always_comb begin
      cnt = '0;
      for (int unsigned o = 0; o < NUM_CLASSES; o++) begin
        if (o < c) begin
          if (!lo_wins_i[pair_index(o, c, NUM_CLASSES)]) cnt = cnt + VOTE_W'(1);
        end else if (o > c) begin
          if (lo_wins_i[pair_index(c, o, NUM_CLASSES)]) cnt = cnt + VOTE_W'(1);
        end
      end
    end

    assign votes_o[c*VOTE_W +: VOTE_W] = cnt;
  end

endmodule

// File: rtl/ovo_argmax.sv
module ovo_argmax #(
  parameter int unsigned NUM_CLASSES = 8,
  parameter int unsigned VOTE_W      = 3,
  parameter int unsigned CLS_W       = 3
) (
  input  logic [NUM_CLASSES*VOTE_W-1:0] votes_i,
  output logic [CLS_W-1:0]              best_o
);

  logic [VOTE_W-1:0] best_cnt;

  // Strict greater-than keeps the earliest class on equal counts.
  always_comb begin
    best_o   = '0;
    best_cnt = votes_i[VOTE_W-1:0];
    for (int unsigned k = 1; k < NUM_CLASSES; k++) begin
      if (votes_i[k*VOTE_W +: VOTE_W] > best_cnt) begin
        best_cnt = votes_i[k*VOTE_W +: VOTE_W];
        best_o   = CLS_W'(k);
      end
    end
  end

endmodule

// File: rtl/ovo_vote_top.sv
module ovo_vote_top
  import ovo_vote_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = DEF_NUM_CLASSES,
  parameter int unsigned SUM_W       = DEF_SUM_W,
  localparam int unsigned NUM_PAIRS  = NUM_CLASSES * (NUM_CLASSES - 1) / 2,
  localparam int unsigned BUS_W      = NUM_PAIRS * SUM_W,
  localparam int unsigned CLS_W      = $clog2(NUM_CLASSES),
  localparam int unsigned VOTE_W     = $clog2(NUM_CLASSES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sum_valid,
  input  logic [BUS_W-1:0] sum_bus,
  input  logic [BUS_W-1:0] bias_bus,
  output logic             res_valid,
  output logic [CLS_W-1:0] res_class
);

  // Stage 1: parallel pair comparisons
  logic [NUM_PAIRS-1:0] lo_wins;

  for (genvar d = 0; d < NUM_PAIRS; d++) begin : g_pair
    ovo_pair_cmp #(.SUM_W(SUM_W)) u_cmp (
      .sum_i     (sum_bus[d*SUM_W +: SUM_W]),
      .bias_i    (bias_bus[d*SUM_W +: SUM_W]),
      .lo_wins_o (lo_wins[d])
    );
  end

  logic [NUM_PAIRS-1:0] win_q, win_d;
  logic                 cmp_vld_q, cmp_vld_d;

  always_comb begin
    cmp_vld_d = sum_valid;
    win_d     = win_q;
    if (sum_valid) win_d = lo_wins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_vld_q <= 1'b0;
      win_q     <= '0;
    end else begin
      cmp_vld_q <= cmp_vld_d;
      win_q     <= win_d;
    end
  end

  // Stage 2: vote count and selection
  logic [NUM_CLASSES*VOTE_W-1:0] votes;
  logic [CLS_W-1:0]              best;

  ovo_vote_tally #(
    .NUM_CLASSES (NUM_CLASSES),
    .VOTE_W      (VOTE_W)
  ) u_tally (
    .lo_wins_i (win_q),
    .votes_o   (votes)
  );

  ovo_argmax #(
    .NUM_CLASSES (NUM_CLASSES),
    .VOTE_W      (VOTE_W),
    .CLS_W       (CLS_W)
  ) u_argmax (
    .votes_i (votes),
    .best_o  (best)
  );

  logic             res_vld_q, res_vld_d;
  logic [CLS_W-1:0] res_cls_q, res_cls_d;

  always_comb begin
    res_vld_d = cmp_vld_q;
    res_cls_d = res_cls_q;
    if (cmp_vld_q) res_cls_d = best;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_q <= 1'b0;
      res_cls_q <= '0;
    end else begin
      res_vld_q <= res_vld_d;
      res_cls_q <= res_cls_d;
    end
  end

  assign res_valid = res_vld_q;
  assign res_class = res_cls_q;

endmodule

// File: rtl/ovo_vote_chk.sv
module ovo_vote_chk #(
  parameter int unsigned NUM_CLASSES = 8,
  parameter int unsigned SUM_W       = 26,
  localparam int unsigned NUM_PAIRS  = NUM_CLASSES * (NUM_CLASSES - 1) / 2,
  localparam int unsigned BUS_W      = NUM_PAIRS * SUM_W,
  localparam int unsigned CLS_W      = $clog2(NUM_CLASSES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sum_valid,
  input logic [BUS_W-1:0] sum_bus,
  input logic [BUS_W-1:0] bias_bus,
  input logic             res_valid,
  input logic [CLS_W-1:0] res_class
);

  logic [1:0] age;
  logic       all_lo, all_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  always_comb begin
    all_lo = 1'b1;
    all_hi = 1'b1;
    for (int unsigned d = 0; d < NUM_PAIRS; d++) begin
      if ($signed(sum_bus[d*SUM_W +: SUM_W]) >  $signed(bias_bus[d*SUM_W +: SUM_W])) all_hi = 1'b0;
      else                                                                           all_lo = 1'b0;
    end
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (res_valid == $past(sum_valid, 2)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((age != 2'd0) && !res_valid) |-> $stable(res_class));

  // R4: if every pair favours its lower class, class code 0 collects all votes.
  assert_low_sweep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd2) && res_valid && $past(sum_valid && all_lo, 2)) |-> (res_class == '0));

  // R2: if no pair favours its lower class, the highest code collects all votes.
  assert_high_sweep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd2) && res_valid && $past(sum_valid && all_hi, 2)) |-> (res_class == CLS_W'(NUM_CLASSES - 1)));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R8: assert (!res_valid && (res_class == '0));
    end
  end

endmodule

bind ovo_vote_top ovo_vote_chk #(
  .NUM_CLASSES (NUM_CLASSES),
  .SUM_W       (SUM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sum_valid (sum_valid),
  .sum_bus   (sum_bus),
  .bias_bus  (bias_bus),
  .res_valid (res_valid),
  .res_class (res_class)
);

// File: tb/ovo_vote_top_tb.sv
module ovo_vote_top_tb;

  localparam int NC = 8;
  localparam int SW = 26;
  localparam int NP = NC * (NC - 1) / 2;
  localparam int PW = NP * SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sum_valid;
  logic [PW-1:0] sum_bus, bias_bus;
  logic          res_valid;
  logic [2:0]    res_class;

  always #4 clk = ~clk;

  ovo_vote_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sum_valid (sum_valid),
    .sum_bus   (sum_bus),
    .bias_bus  (bias_bus),
    .res_valid (res_valid),
    .res_class (res_class)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  int    v1 = 0, v2 = 0, c1 = 0, c2 = 0, held = 0;
  string t1 = "", t2 = "";
  logic [PW-1:0] ts, tb;

  function automatic int model(input logic [PW-1:0] s, input logic [PW-1:0] b);
    int votes[NC];
    int d = 0;
    int best = 0;
    for (int i = 0; i < NC; i++) votes[i] = 0;
    for (int i = 0; i < NC; i++) begin
      for (int j = i + 1; j < NC; j++) begin
        longint sv = longint'($signed(s[d*SW +: SW]));
        longint bv = longint'($signed(b[d*SW +: SW]));
        if (sv - bv > 0) votes[i]++;
        else             votes[j]++;
        d++;
      end
    end
    for (int k = 1; k < NC; k++) if (votes[k] > votes[best]) best = k;
    return best;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [PW-1:0] s, input logic [PW-1:0] b, input string tag);
    @(negedge clk);
    check("R6 valid", int'(res_valid), v2);
    if (v2 != 0) begin
      check(t2, int'(res_class), c2);
      held = c2;
    end else begin
      check("R7 hold", int'(res_class), held);
    end
    v2 = v1; c2 = c1; t2 = t1;
    sum_valid = v;
    sum_bus   = s;
    bias_bus  = b;
    v1 = v ? 1 : 0;
    c1 = model(s, b);
    t1 = tag;
  endtask

  // Builds operands from a pair-outcome vector: bit set means the lower class wins.
  task automatic from_wins(input logic [NP-1:0] w, input bit equal_lose);
    for (int d = 0; d < NP; d++) begin
      int bv = int'($urandom_range(0, 1 << 20)) - (1 << 19);
      tb[d*SW +: SW] = SW'(bv);
      ts[d*SW +: SW] = w[d] ? SW'(bv + 1) : SW'(equal_lose ? bv : bv - 3);
    end
  endtask

  function automatic logic [NP-1:0] cyclic(input bit low_half);
    logic [NP-1:0] w;
    int d = 0;
    for (int i = 0; i < NC; i++) begin
      for (int j = i + 1; j < NC; j++) begin
        if (j - i < 4)       w[d] = 1'b1;
        else if (j - i > 4)  w[d] = 1'b0;
        else                 w[d] = low_half;
        d++;
      end
    end
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sum_valid = 1'b0; sum_bus = '0; bias_bus = '0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", int'(res_valid), 0);
    check("R8 reset class", int'(res_class), 0);
    rst_n = 1'b1;

    // R4: lower class always wins -> code 0
    from_wins('1, 1'b1); step(1, ts, tb, "R4 all-low");
    // R2: equal operands -> higher class -> code 7
    from_wins('0, 1'b1); step(1, ts, tb, "R2 all-equal");
    from_wins('0, 1'b0); step(1, ts, tb, "R2 all-below");
    // R1: class 7 beats everyone except 6 (pair 27), class 6 wins all -> code 6
    begin
      logic [NP-1:0] w = '0;
      w[27] = 1'b1;
      from_wins(w, 1'b1); step(1, ts, tb, "R1 pair order");
    end
    // R5: cyclic ties
    from_wins(cyclic(1'b1), 1'b1); step(1, ts, tb, "R5 tie low");
    step(0, '0, '0, "idle");
    from_wins(cyclic(1'b0), 1'b0); step(1, ts, tb, "R5 tie high");
    // R3: extreme opposite signs
    for (int d = 0; d < NP; d++) begin
      ts[d*SW +: SW] = {1'b0, {(SW-1){1'b1}}};
      tb[d*SW +: SW] = {1'b1, {(SW-1){1'b0}}};
    end
    step(1, ts, tb, "R3 max minus min");
    step(1, tb, ts, "R3 min minus max");
    repeat (3) step(0, ts, tb, "R7 gap");

    // Random mix of back-to-back and gapped vectors
    for (int n = 0; n < 1500; n++) begin
      int mode = int'($urandom_range(0, 2));
      for (int d = 0; d < NP; d++) begin
        logic [SW-1:0] bv = SW'($urandom);
        tb[d*SW +: SW] = bv;
        if (mode == 0)      ts[d*SW +: SW] = SW'($urandom);
        else if (mode == 1) ts[d*SW +: SW] = bv + SW'(int'($urandom_range(0, 2)) - 1);
        else                ts[d*SW +: SW] = ($urandom_range(0, 1) != 0) ? {1'b0, {(SW-1){1'b1}}} : {1'b1, {(SW-1){1'b0}}};
      end
      step(($urandom_range(0, 3) != 0), ts, tb, "R4 random");
    end
    repeat (3) step(0, '0, '0, "flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule